// File: doc/BRIEF.md
# Multi-Channel Single/Double-Edge PWM Generator

This block produces six pulse-width-modulated outputs from one shared timebase. A prescale counter divides the clock, and every time it wraps the timer count steps once. Seven compare values, numbered 0 to 6, watch the timer count. Compare 0 normally closes the period by returning the count to zero. Compares 1 to 6 each end the high phase of the output with the same number.

Each output has one mode bit. In single-edge mode the output rises when compare 0 hits. In double-edge mode it rises when the compare one below its own number hits, so both edges can sit anywhere in the period. For every compare, software picks whether a hit restarts the count, freezes the count, or raises a sticky flag.

New compare values are written into a staging copy first. Each one takes effect only after its load bit is armed and the period wraps on compare 0, or at once while the counter is held in reset. Software reaches all settings through a small word-wide register port with a combinational read path.

Top module: `pwm_multi_edge`

## Requirements
- R1: After reset, every readable register returns 0, all six outputs are low and `irq` is low.
- R2: Register map on `reg_addr`: 0x0 control (bit 0 run, bit 1 hold, where hold keeps both counters at 0); 0x1 prescale limit; 0x2 compare actions, with compare m using bits 3m (flag), 3m+1 (restart count) and 3m+2 (freeze); 0x3 output control, with bit n-1 enabling output n and bit 7+n selecting double-edge for output n; 0x4 load bits, bit m for compare m; 0x5 flags; 0x6 timer count (read only); 0x8+m staging value of compare m. Unlisted addresses read 0.
- R3: While running with prescale limit P, the timer count steps once every P+1 clocks. With restart-on-compare-0 set, the period is (C0+1)(P+1) clocks.
- R4: An output in single-edge mode is set by a compare-0 hit and cleared by its own compare hit. For C_n < C0 it is high for (C_n+1)(P+1) clocks per period. For C_n > C0 it stays high.
- R5: An output n in double-edge mode is set by a hit of compare n-1 and cleared by a hit of compare n. This holds for every n, including compare 5 driving output 6. The high time is (C_n - C_{n-1}) steps when C_{n-1} < C_n, and one period minus (C_{n-1} - C_n) steps when C_{n-1} > C_n.
- R6: When set and clear fall on the same count, the clear wins and the output stays low. An output whose enable bit is 0 is low.
- R7: A hit on a compare with restart enabled puts the timer count back to 0 at the next step, so with restart on compare m the count never exceeds C_m.
- R8: A hit on a compare with freeze enabled stops both counters at their present values, leaving the count equal to that compare value, and clears the run bit.
- R9: A hit on a compare with flag enabled sets flag bit m (address 0x5), and `irq` is the OR of all flags. Writing 1 to a flag bit clears it. Writing 0 leaves it unchanged. A hit in the same cycle as a clear wins. Bits 7 to 10 and above read 0.
- R10: A write to 0x8+m changes only the staging value, which reads back at once. The active compare changes only when load bit m is set and either compare 0 hits with restart enabled or hold is set. The load bit then returns to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| pwm_out | output | 6 | PWM outputs, bit n-1 is output n |
| irq | output | 1 | OR of all compare flags |

## Verification
Setting an output and clearing it are the two functions that can land on the same timer step. The bench provokes this in two ways. One is to make a single-edge output's own compare equal to compare 0. The other is to give a double-edge output two equal compare values. In both cases the bench counts the output's high clocks over a whole steady-state period and expects zero, while a neighbouring output in the same vector must still show its computed duty. This shows the clear won, and that the output was not simply stuck.

// File: rtl/pwm_multi_edge_pkg.sv
// Package: shared register addresses and compare-action bit layout.
// Assumes a 4-bit register address space and a 32-bit data word.
package pwm_multi_edge_pkg;
    localparam logic [3:0] A_CTRL       = 4'h0;
    localparam logic [3:0] A_PRESCALE   = 4'h1;
    localparam logic [3:0] A_MATCH_CTL  = 4'h2;
    localparam logic [3:0] A_OUT_CTL    = 4'h3;
    localparam logic [3:0] A_LOAD       = 4'h4;
    localparam logic [3:0] A_FLAGS      = 4'h5;
    localparam logic [3:0] A_COUNT      = 4'h6;
    localparam logic [3:0] A_MATCH_BASE = 4'h8;

    localparam int MC_BITS = 3;   // action bits per compare
    localparam int MC_IRQ  = 0;
    localparam int MC_RST  = 1;
    localparam int MC_STOP = 2;
    localparam int DBL_LSB = 8;   // output-control field for edge mode
endpackage

// File: rtl/pwm_prescale_timer.sv
// Prescaler and timer counter.
// The prescale counter runs 0..limit, and each wrap is one "tick" that steps
// the timer count. A restart request zeroes the count on that tick, and a
// freeze request keeps both counters where they are. Hold forces both to 0.
// Assumes the restart and freeze requests are only meaningful on a tick.
module pwm_prescale_timer #(
    parameter int TW = 16,
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          hold,
    input  logic [PW-1:0] limit,
    input  logic          req_restart,
    input  logic          req_freeze,
    output logic          tick,
    output logic [TW-1:0] count
);
    logic [PW-1:0] pc_q;
    logic [TW-1:0] tc_q;

    // Tick when the prescale counter reaches its limit while counting.
    assign tick  = run && !hold && (pc_q == limit);
    assign count = tc_q;

    // Advance prescale and timer counts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
            tc_q <= '0;
        end else if (hold) begin
            pc_q <= '0;
            tc_q <= '0;
        end else if (run) begin
            if (tick) begin
                if (!req_freeze) begin
                    pc_q <= '0;
                    tc_q <= req_restart ? '0 : tc_q + 1'b1;
                end
            end else begin
                pc_q <= pc_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pwm_match_bank.sv
// Compare bank: for each compare, a staging value, an active value and a load bit.
// A hit is a tick on which the timer count equals the active value.
// A staged value moves to active when its load bit is set and the load
// window is open, and the load bit then clears.
// Assumes a write to the load bits in the same cycle takes precedence.
module pwm_match_bank #(
    parameter int NM = 7,
    parameter int TW = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NM-1:0]          wr_stage,
    input  logic [TW-1:0]          wdata,
    input  logic                   ld_wr,
    input  logic [NM-1:0]          ld_wdata,
    input  logic                   load_window,
    input  logic                   tick,
    input  logic [TW-1:0]          count,
    output logic [NM-1:0]          hit,
    output logic [NM-1:0]          ld_pend,
    output logic [NM-1:0]          load_fire,
    output logic [NM-1:0][TW-1:0]  stage
);
    for (genvar m = 0; m < NM; m++) begin : g_cmp
        logic [TW-1:0] stage_q;
        logic [TW-1:0] active_q;
        logic          pend_q;

        assign stage[m]     = stage_q;
        assign ld_pend[m]   = pend_q;
        assign load_fire[m] = pend_q && load_window;
        assign hit[m]       = tick && (count == active_q);

        // Staging write, transfer to the active value, and load-bit upkeep.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_q  <= '0;
                active_q <= '0;
                pend_q   <= 1'b0;
            end else begin
                if (wr_stage[m]) stage_q <= wdata;
                if (load_fire[m]) active_q <= stage_q;
                if (ld_wr) pend_q <= ld_wdata[m];
                else if (load_fire[m]) pend_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pwm_edge_out.sv
// Output stage: one set/clear flop per output.
// Output i+1 is set by compare 0 (single-edge) or compare i (double-edge),
// and cleared by compare i+1. Clear beats set, and a disabled output is low.
// Assumes hit[] is a registered-input, one-cycle pulse per tick.
module pwm_edge_out #(
    parameter int NO = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NO:0]   hit,
    input  logic [NO-1:0] enable,
    input  logic [NO-1:0] dbl,
    output logic [NO-1:0] pwm_out
);
    for (genvar i = 0; i < NO; i++) begin : g_out
        logic set_ev, clr_ev, q;
        assign set_ev     = dbl[i] ? hit[i] : hit[0];
        assign clr_ev     = hit[i+1];
        assign pwm_out[i] = q;

        // Update the output level with clear taking priority.
        always_ff @(posedge clk) begin
            if (!rst_n)        q <= 1'b0;
            else if (!enable[i]) q <= 1'b0;
            else if (clr_ev)   q <= 1'b0;
            else if (set_ev)   q <= 1'b1;
        end
    end
endmodule

// File: rtl/pwm_multi_edge.sv
// Top: register port, control state and flags around the timer, compare
// bank and output stage. Reads are combinational from reg_addr.
// Assumes NO <= 7 so the compare staging addresses fit in 4 bits, and
// TW, PW <= 32.
module pwm_multi_edge
    import pwm_multi_edge_pkg::*;
#(
    parameter int NO = 6,
    parameter int TW = 16,
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [3:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic [NO-1:0] pwm_out,
    output logic          irq
);
    localparam int NM  = NO + 1;
    localparam int MCW = MC_BITS * NM;

    logic                  run_q, hold_q;
    logic [PW-1:0]         pre_q;
    logic [MCW-1:0]        mctl_q;
    logic [NO-1:0]         en_q, dbl_q;
    logic [NM-1:0]         flags_q;

    logic                  tick;
    logic [TW-1:0]         tc;
    logic [NM-1:0]         hit, ld_pend, load_fire, wr_stage;
    logic [NM-1:0]         irq_en, rst_en, stop_en, w1c;
    logic [NM-1:0][TW-1:0] stage;
    logic                  stop_hit, rst_hit, load_window;
    logic                  unused_wdata;

    assign unused_wdata = &{1'b0, reg_wdata};

    for (genvar m = 0; m < NM; m++) begin : g_dec
        assign irq_en[m]   = mctl_q[MC_BITS*m + MC_IRQ];
        assign rst_en[m]   = mctl_q[MC_BITS*m + MC_RST];
        assign stop_en[m]  = mctl_q[MC_BITS*m + MC_STOP];
        assign wr_stage[m] = reg_wr && (reg_addr == A_MATCH_BASE + 4'(m));
    end

    assign stop_hit    = |(hit & stop_en);
    assign rst_hit     = |(hit & rst_en);
    assign load_window = hold_q || (hit[0] && rst_en[0]);
    assign w1c         = (reg_wr && reg_addr == A_FLAGS) ? reg_wdata[NM-1:0] : '0;
    assign irq         = |flags_q;

    // Control register writes; a freeze hit drops the run bit last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            hold_q <= 1'b0;
            pre_q  <= '0;
            mctl_q <= '0;
            en_q   <= '0;
            dbl_q  <= '0;
        end else begin
            if (reg_wr) begin
                case (reg_addr)
                    A_CTRL:      begin run_q <= reg_wdata[0]; hold_q <= reg_wdata[1]; end
                    A_PRESCALE:  pre_q  <= reg_wdata[PW-1:0];
                    A_MATCH_CTL: mctl_q <= reg_wdata[MCW-1:0];
                    A_OUT_CTL:   begin
                        en_q  <= reg_wdata[NO-1:0];
                        dbl_q <= reg_wdata[DBL_LSB +: NO];
                    end
                    default: ;
                endcase
            end
            if (stop_hit) run_q <= 1'b0;
        end
    end

    // Sticky flags: hardware set wins over a same-cycle write-one clear.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~w1c) | (hit & irq_en);
    end

    // Combinational register read.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL:      reg_rdata[1:0]      = {hold_q, run_q};
            A_PRESCALE:  reg_rdata[PW-1:0]   = pre_q;
            A_MATCH_CTL: reg_rdata[MCW-1:0]  = mctl_q;
            A_OUT_CTL:   begin
                reg_rdata[NO-1:0]          = en_q;
                reg_rdata[DBL_LSB +: NO]   = dbl_q;
            end
            A_LOAD:      reg_rdata[NM-1:0]   = ld_pend;
            A_FLAGS:     reg_rdata[NM-1:0]   = flags_q;
            A_COUNT:     reg_rdata[TW-1:0]   = tc;
            default: begin
                for (int m = 0; m < NM; m++) begin
                    if (reg_addr == A_MATCH_BASE + 4'(m)) reg_rdata[TW-1:0] = stage[m];
                end
            end
        endcase
    end

    pwm_prescale_timer #(.TW(TW), .PW(PW)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run_q),
        .hold        (hold_q),
        .limit       (pre_q),
        .req_restart (rst_hit),
        .req_freeze  (stop_hit),
        .tick        (tick),
        .count       (tc)
    );

    pwm_match_bank #(.NM(NM), .TW(TW)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_stage    (wr_stage),
        .wdata       (reg_wdata[TW-1:0]),
        .ld_wr       (reg_wr && reg_addr == A_LOAD),
        .ld_wdata    (reg_wdata[NM-1:0]),
        .load_window (load_window),
        .tick        (tick),
        .count       (tc),
        .hit         (hit),
        .ld_pend     (ld_pend),
        .load_fire   (load_fire),
        .stage       (stage)
    );

    pwm_edge_out #(.NO(NO)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (hit),
        .enable  (en_q),
        .dbl     (dbl_q),
        .pwm_out (pwm_out)
    );
endmodule

// File: rtl/pwm_multi_edge_chk.sv
// Checker: temporal properties of the PWM block, bound into the top.
// Assumes the bench holds reset for at least one clock at start.
module pwm_multi_edge_chk
    import pwm_multi_edge_pkg::*;
#(
    parameter int NO = 6,
    parameter int TW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [NO:0]   hit,
    input logic [TW-1:0] tc,
    input logic          run_q,
    input logic [NO:0]   rst_en,
    input logic [NO:0]   stop_en,
    input logic [NO:0]   irq_en,
    input logic [NO:0]   flags_q,
    input logic [NO:0]   ld_pend,
    input logic [NO:0]   load_fire,
    input logic [NO-1:0] en_q,
    input logic [NO-1:0] pwm_out,
    input logic          reg_wr,
    input logic [3:0]    reg_addr,
    input logic [31:0]   reg_rdata
);
    AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (pwm_out & ~$past(en_q)) == '0); // R6
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit[NO:1]) |=> (pwm_out & $past(hit[NO:1])) == '0); // R6
    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(hit & rst_en)) && !(|(hit & stop_en))) |=> tc == '0); // R7
    AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (|(hit & stop_en)) |=> (tc == $past(tc)) && !run_q); // R8
    AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (|(hit & irq_en)) |=> (flags_q & $past(hit & irq_en)) == $past(hit & irq_en)); // R9
    AST_FLAG_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == A_FLAGS) |-> reg_rdata[31:NO+1] == '0); // R9
    AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ((|load_fire) && !(reg_wr && reg_addr == A_LOAD)) |=> (ld_pend & $past(load_fire)) == '0); // R10
endmodule

bind pwm_multi_edge pwm_multi_edge_chk #(.NO(NO), .TW(TW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit       (hit),
    .tc        (tc),
    .run_q     (run_q),
    .rst_en    (rst_en),
    .stop_en   (stop_en),
    .irq_en    (irq_en),
    .flags_q   (flags_q),
    .ld_pend   (ld_pend),
    .load_fire (load_fire),
    .en_q      (en_q),
    .pwm_out   (pwm_out),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata)
);

// File: tb/tb_pwm_multi_edge.sv
module tb_pwm_multi_edge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [5:0]  pwm_out;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    int cnt [6];

    pwm_multi_edge dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out), .irq(irq)
    );

    always #5 clk = ~clk;

    // Vector fields: {prescale, c0, c1, c2, output-2 double-edge}
    localparam logic [39:0] VEC [8] = '{
        {8'd0, 8'd9, 8'd3, 8'd6, 8'd0},
        {8'd0, 8'd9, 8'd3, 8'd6, 8'd1},
        {8'd1, 8'd7, 8'd2, 8'd5, 8'd1},
        {8'd2, 8'd5, 8'd4, 8'd1, 8'd1},
        {8'd0, 8'd8, 8'd8, 8'd4, 8'd0},
        {8'd0, 8'd8, 8'd4, 8'd4, 8'd1},
        {8'd0, 8'd6, 8'd9, 8'd0, 8'd0},
        {8'd3, 8'd4, 8'd0, 8'd4, 8'd1}
    };

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic measure(input int n);
        for (int k = 0; k < 6; k++) cnt[k] = 0;
        repeat (n) begin
            @(negedge clk);
            for (int k = 0; k < 6; k++) cnt[k] += int'(pwm_out[k]);
        end
    endtask

    // Expected single-edge high clocks per period (R4, R6).
    function automatic int exp_single(int p, int c0, int cn);
        if (cn == c0) return 0;
        if (cn > c0)  return (c0 + 1) * (p + 1);
        return (cn + 1) * (p + 1);
    endfunction

    // Expected double-edge high clocks per period (R5, R6).
    function automatic int exp_double(int p, int c0, int ca, int cb);
        if (ca == cb) return 0;
        if (ca < cb)  return (cb - ca) * (p + 1);
        return (c0 + 1 - (ca - cb)) * (p + 1);
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        int p, c0, c1, c2, dbl, per, mx;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        #1;
        check("R1", "pwm_out", pwm_out, 0);
        check("R1", "irq", irq, 0);
        rd(4'h0, v); check("R1", "ctrl", v, 0);
        rd(4'h2, v); check("R1", "compare actions", v, 0);
        rd(4'h3, v); check("R1", "output ctrl", v, 0);
        rd(4'h5, v); check("R1", "flags", v, 0);
        rd(4'h6, v); check("R1", "count", v, 0);

        // R2 map read-back
        wr(4'h1, 32'd5);      rd(4'h1, v); check("R2", "prescale readback", v, 5);
        wr(4'hB, 32'h1234);   rd(4'hB, v); check("R2", "compare3 staging", v, 32'h1234);
        rd(4'h7, v); check("R2", "unlisted address", v, 0);

        // Vector table: R3 period, R4 single, R5 double, R6 same-step clear
        for (int i = 0; i < 8; i++) begin
            p = int'(VEC[i][39:32]); c0 = int'(VEC[i][31:24]);
            c1 = int'(VEC[i][23:16]); c2 = int'(VEC[i][15:8]); dbl = int'(VEC[i][7:0]);
            per = (c0 + 1) * (p + 1);
            wr(4'h0, 32'h2);
            wr(4'h1, 32'(p));
            wr(4'h8, 32'(c0)); wr(4'h9, 32'(c1)); wr(4'hA, 32'(c2));
            wr(4'h2, 32'h2);
            wr(4'h3, 32'h3 | (dbl != 0 ? 32'h200 : 32'h0));
            wr(4'h4, 32'h7);
            repeat (2) @(negedge clk);
            wr(4'h0, 32'h1);
            repeat (2 * per) @(negedge clk);
            measure(per);
            check("R4", $sformatf("vec%0d out1 high", i), cnt[0], exp_single(p, c0, c1));
            if (dbl != 0)
                check("R5", $sformatf("vec%0d out2 double high", i), cnt[1], exp_double(p, c0, c1, c2));
            else
                check("R3", $sformatf("vec%0d out2 single high", i), cnt[1], exp_single(p, c0, c2));
        end

        // R10 staging without load bit leaves duty unchanged
        wr(4'h0, 32'h2); wr(4'h1, 32'd0);
        wr(4'h8, 32'd9); wr(4'h9, 32'd2); wr(4'h2, 32'h2); wr(4'h3, 32'h1);
        wr(4'h4, 32'h3); repeat (2) @(negedge clk); wr(4'h0, 32'h1);
        repeat (20) @(negedge clk);
        wr(4'h9, 32'd6);
        repeat (20) @(negedge clk);
        measure(10); check("R10", "old duty kept", cnt[0], 3);
        rd(4'h9, v); check("R10", "staging reads new", v, 6);
        rd(4'h4, v); check("R10", "load bits idle", v, 0);
        wr(4'h4, 32'h2);
        rd(4'h4, v); check("R10", "load bit pending", v, 2);
        repeat (20) @(negedge clk);
        rd(4'h4, v); check("R10", "load bit self-clears", v, 0);
        measure(10); check("R10", "new duty applied", cnt[0], 7);

        // R9 flags, write-one-to-clear, write-zero no effect
        wr(4'h2, 32'hA);
        repeat (12) @(negedge clk);
        rd(4'h5, v); check("R9", "flag1 set", v & 32'h2, 2);
        check("R9", "irq high", irq, 1);
        wr(4'h2, 32'h2);
        wr(4'h5, 32'h0);
        rd(4'h5, v); check("R9", "write zero keeps flag", v, 2);
        wr(4'h5, 32'h7FF);
        rd(4'h5, v); check("R9", "flags cleared, reserved zero", v, 0);
        check("R9", "irq low", irq, 0);

        // R8 freeze on compare 2
        wr(4'h0, 32'h2); wr(4'hA, 32'd4); wr(4'h2, 32'h102); wr(4'h4, 32'h7);
        repeat (2) @(negedge clk); wr(4'h0, 32'h1);
        repeat (30) @(negedge clk);
        rd(4'h6, v); check("R8", "count frozen at compare", v, 4);
        rd(4'h0, v); check("R8", "run bit cleared", v, 0);
        repeat (10) @(negedge clk);
        rd(4'h6, v); check("R8", "count still frozen", v, 4);

        // R7 restart on compare 1 only
        wr(4'h0, 32'h2); wr(4'h8, 32'd20); wr(4'h9, 32'd5); wr(4'h2, 32'h10);
        wr(4'h4, 32'h3); repeat (2) @(negedge clk); wr(4'h0, 32'h1);
        mx = 0;
        for (int k = 0; k < 60; k++) begin
            rd(4'h6, v);
            if (int'(v) > mx) mx = int'(v);
        end
        check("R7", "max count with restart on compare1", mx, 5);

        // R5 compare 5 drives output 6; R6 disabled output 5 low
        wr(4'h0, 32'h2); wr(4'h8, 32'd9); wr(4'hD, 32'd2); wr(4'hE, 32'd7);
        wr(4'h2, 32'h2); wr(4'h3, 32'h2020); wr(4'h4, 32'h61);
        repeat (2) @(negedge clk); wr(4'h0, 32'h1);
        repeat (20) @(negedge clk);
        measure(10);
        check("R5", "out6 double from compare5", cnt[5], 5);
        check("R6", "out5 disabled low", cnt[4], 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule